// File: doc/BRIEF.md
# Isochronous IN Endpoint Double Buffer

This block holds outgoing isochronous data for one device-side IN endpoint. Firmware pushes bytes into whichever of two packet buffers is free and then commits the packet. A commit records the byte count and passes the buffer to the send side. When the host's IN token arrives, the block streams the oldest eligible packet to the serial engine, marking its first and last beats. If no packet is eligible, it sends a zero-length packet and sets a sticky underrun flag.

Packet sizes of isochronous traffic vary from frame to frame. For that reason a packet only becomes ready on an explicit commit, never when its buffer reaches full size. To get strict one-frame-ahead double buffering, firmware sets the wait-for-frame-start option. A packet committed while this option is set is held back until the next start-of-frame token. This keeps a packet loaded early in a frame from leaving in that same frame.

Top module: `iso_in_buf`

## Requirements
- R1: After reset, tx_valid, underrun and commit_err are all low, and both buffers are empty.
- R2: A commit records the number of bytes written since the previous commit. The next send of that buffer emits exactly that many beats, in write order, with tx_sop on the first beat only and tx_eop on the last beat only. A byte written in the same cycle as commit is dropped.
- R3: Packets are sent in the order they were committed. A buffer becomes free once its last beat is accepted (tx_valid and tx_ready both high).
- R4: Two buffers are available, so a second packet can be loaded and committed while the first waits. A commit while both buffers hold packets is ignored, leaves both packets intact, and raises commit_err for exactly the cycle after it.
- R5: With wait_sof high at commit time, the packet cannot be sent until a sof pulse occurs in a later cycle than the commit. An IN token before that sof gets a zero-length packet instead. A sof in the same cycle as the commit does not release the packet.
- R6: With wait_sof low at commit time, the packet is sent on the next IN token, with no sof needed.
- R7: An IN token with no eligible packet produces a single beat with tx_valid, tx_sop, tx_eop and tx_zlp all high, and sets underrun in the cycle after the token.
- R8: underrun stays high until a cycle with underrun_clr high. If an underrun occurs in the same cycle as underrun_clr, the flag stays set.
- R9: An IN token that arrives while a packet is being sent is ignored. It neither disturbs the packet nor causes an extra packet or an underrun.
- R10: A committed packet of zero bytes is sent as a single beat with tx_zlp high. It does not set underrun, and it frees its buffer.
- R11: While tx_valid is high and tx_ready is low, the current beat (data, sop, eop) is held unchanged.
- R12: Writes beyond DEPTH bytes into one buffer are dropped, so the recorded count saturates at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Firmware byte write strobe |
| wr_data | input | DATA_W | Firmware byte |
| commit | input | 1 | Mark the loaded bytes as one packet |
| wait_sof | input | 1 | Hold newly committed packets until the next frame start |
| sof | input | 1 | Start-of-frame token pulse |
| in_tok | input | 1 | IN token pulse |
| underrun_clr | input | 1 | Write-one-to-clear for underrun |
| tx_ready | input | 1 | Serial engine accepts the current beat |
| tx_valid | output | 1 | Beat present |
| tx_data | output | DATA_W | Beat data (zero on a zero-length beat) |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_zlp | output | 1 | Zero-length packet beat |
| underrun | output | 1 | Sticky underrun flag |
| commit_err | output | 1 | One-cycle pulse on a rejected commit |

## Verification
A wrong buffer-ownership bit shows up at the first IN token that follows it. The symptoms are a zero-length packet where data was due, a repeat of a packet already sent, or packets swapped out of commit order. A wrong byte count or read index shows up inside that same send, as a beat with wrong data or an end marker on the wrong beat. A wrong arming bit shows up only at the IN token of the frame concerned. For that reason the bench places IN tokens on both sides of each start-of-frame pulse.

// File: rtl/iso_in_buf.sv
module iso_in_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  input  logic              wait_sof,
  input  logic              sof,
  input  logic              in_tok,
  input  logic              underrun_clr,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              tx_zlp,
  output logic              underrun,
  output logic              commit_err
);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_ZLP} st_t;

  st_t              st;
  logic [DATA_W-1:0] mem [2][DEPTH];
  logic [CNT_W-1:0] len [2];
  logic [1:0]       full, armed;
  logic             ld_sel, rd_sel, buf_pkt;
  logic [CNT_W-1:0] wcnt, rd_idx, nxt_idx;

  wire can_wr    = wr_valid && !commit && !full[ld_sel] && (wcnt < CNT_W'(DEPTH));
  wire commit_ok = commit && !full[ld_sel];
  wire eligible  = full[rd_sel] && armed[rd_sel];
  wire start     = in_tok && (st == S_IDLE);
  wire beat_done = tx_valid && tx_ready;
  assign nxt_idx = rd_idx + 1'b1;
  wire last_data = (nxt_idx == len[rd_sel]);
  wire free_now  = beat_done && tx_eop && buf_pkt;

  assign tx_valid = (st != S_IDLE);
  assign tx_zlp   = (st == S_ZLP);
  assign tx_sop   = tx_zlp || (st == S_DATA && rd_idx == '0);
  assign tx_eop   = tx_zlp || (st == S_DATA && last_data);
  assign tx_data  = (st == S_DATA) ? mem[rd_sel][rd_idx[IDX_W-1:0]] : '0;

  always_ff @(posedge clk)
    if (can_wr) mem[ld_sel][wcnt[IDX_W-1:0]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      full       <= '0;
      armed      <= '0;
      len[0]     <= '0;
      len[1]     <= '0;
      ld_sel     <= 1'b0;
      rd_sel     <= 1'b0;
      buf_pkt    <= 1'b0;
      wcnt       <= '0;
      rd_idx     <= '0;
      underrun   <= 1'b0;
      commit_err <= 1'b0;
    end else begin
      commit_err <= commit && full[ld_sel];
      if (can_wr) wcnt <= wcnt + 1'b1;

      for (int i = 0; i < 2; i++)
        if (sof && full[i]) armed[i] <= 1'b1;

      if (free_now) begin
        full[rd_sel]  <= 1'b0;
        armed[rd_sel] <= 1'b0;
        rd_sel        <= ~rd_sel;
      end

      if (commit_ok) begin
        full[ld_sel]  <= 1'b1;
        armed[ld_sel] <= !wait_sof;
        len[ld_sel]   <= wcnt;
        ld_sel        <= ~ld_sel;
        wcnt          <= '0;
      end

      if (start && !eligible) underrun <= 1'b1;
      else if (underrun_clr)  underrun <= 1'b0;

      unique case (st)
        S_IDLE: if (start) begin
          rd_idx  <= '0;
          buf_pkt <= eligible;
          st      <= (eligible && len[rd_sel] != '0) ? S_DATA : S_ZLP;
        end
        S_DATA: if (beat_done) begin
          if (last_data) begin
            st     <= S_IDLE;
            rd_idx <= '0;
          end else begin
            rd_idx <= nxt_idx;
          end
        end
        S_ZLP: if (beat_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_err |-> $past(commit));

  p_zlp_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> tx_valid && tx_sop && tx_eop);

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !underrun_clr |=> underrun);

  p_no_sop_midpkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done && !tx_eop |=> tx_valid && !tx_sop);

endmodule

// File: tb/iso_in_buf_tb.sv
`timescale 1ns/1ps
module iso_in_buf_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, commit = 0, wait_sof = 0, sof = 0, in_tok = 0, underrun_clr = 0, tx_ready = 1;
  logic [DATA_W-1:0] wr_data = '0;
  logic tx_valid, tx_sop, tx_eop, tx_zlp, underrun, commit_err;
  logic [DATA_W-1:0] tx_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iso_in_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .commit(commit),
    .wait_sof(wait_sof), .sof(sof), .in_tok(in_tok), .underrun_clr(underrun_clr),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_zlp(tx_zlp), .underrun(underrun), .commit_err(commit_err));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(int n, int seed);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = DATA_W'(seed + i);
      @(negedge clk);
    end
    wr_valid = 0;
    commit = 1;
    @(negedge clk);
    commit = 0;
  endtask

  task automatic pulse_in();
    in_tok = 1;
    @(negedge clk);
    in_tok = 0;
  endtask

  task automatic get_pkt(int n, int seed, string tag);
    for (int i = 0; i < n; i++) begin
      check({tag, " valid"}, tx_valid, 1);
      check({tag, " data"}, tx_data, (seed + i) % 256);
      check({tag, " sop"}, tx_sop, i == 0);
      check({tag, " eop"}, tx_eop, i == n - 1);
      check({tag, " zlp"}, tx_zlp, 0);
      @(negedge clk);
    end
    check({tag, " idle after"}, tx_valid, 0);
  endtask

  task automatic get_zlp(string tag);
    check({tag, " zlp valid"}, tx_valid, 1);
    check({tag, " zlp flag"}, tx_zlp, 1);
    check({tag, " zlp sop"}, tx_sop, 1);
    check({tag, " zlp eop"}, tx_eop, 1);
    @(negedge clk);
    check({tag, " idle after zlp"}, tx_valid, 0);
  endtask

  task automatic clear_underrun();
    underrun_clr = 1;
    @(negedge clk);
    underrun_clr = 0;
  endtask

  task automatic t_reset();
    check("R1 tx_valid", tx_valid, 0);
    check("R1 underrun", underrun, 0);
    check("R1 commit_err", commit_err, 0);
  endtask

  task automatic t_basic();
    wait_sof = 0;
    load(5, 10);
    pulse_in();
    get_pkt(5, 10, "R2 R6 basic");
    check("R6 no underrun", underrun, 0);
  endtask

  task automatic t_underrun();
    pulse_in();
    check("R7 underrun set", underrun, 1);
    get_zlp("R7 empty");
    @(negedge clk);
    check("R8 sticky", underrun, 1);
    in_tok = 1; underrun_clr = 1;
    @(negedge clk);
    in_tok = 0; underrun_clr = 0;
    check("R8 set wins over clear", underrun, 1);
    get_zlp("R8 zlp");
    clear_underrun();
    check("R8 cleared", underrun, 0);
  endtask

  task automatic t_order();
    load(3, 40);
    load(4, 80);
    commit = 1;
    @(negedge clk);
    commit = 0;
    check("R4 commit_err pulse", commit_err, 1);
    @(negedge clk);
    check("R4 commit_err one cycle", commit_err, 0);
    pulse_in();
    get_pkt(3, 40, "R3 first");
    pulse_in();
    get_pkt(4, 80, "R3 R4 second");
    check("R3 no underrun", underrun, 0);
    pulse_in();
    get_zlp("R3 freed");
    check("R3 freed underrun", underrun, 1);
    clear_underrun();
  endtask

  task automatic t_wait_sof();
    wait_sof = 1;
    load(2, 120);
    pulse_in();
    check("R5 held underrun", underrun, 1);
    get_zlp("R5 held");
    clear_underrun();
    sof = 1;
    @(negedge clk);
    sof = 0;
    pulse_in();
    get_pkt(2, 120, "R5 after sof");
    check("R5 no underrun", underrun, 0);
    wr_valid = 1; wr_data = 8'd200;
    @(negedge clk);
    wr_valid = 0; commit = 1; sof = 1;
    @(negedge clk);
    commit = 0; sof = 0;
    pulse_in();
    get_zlp("R5 same-cycle sof");
    clear_underrun();
    sof = 1;
    @(negedge clk);
    sof = 0;
    pulse_in();
    get_pkt(1, 200, "R5 next sof");
    wait_sof = 0;
  endtask

  task automatic t_busy_in();
    load(4, 60);
    pulse_in();
    check("R9 beat0", tx_data, 60);
    in_tok = 1;
    @(negedge clk);
    in_tok = 0;
    for (int i = 1; i < 4; i++) begin
      check("R9 data", tx_data, 60 + i);
      check("R9 valid", tx_valid, 1);
      @(negedge clk);
    end
    check("R9 no extra packet", tx_valid, 0);
    check("R9 no underrun", underrun, 0);
  endtask

  task automatic t_zero_len();
    commit = 1;
    @(negedge clk);
    commit = 0;
    check("R10 no commit_err", commit_err, 0);
    pulse_in();
    get_zlp("R10 empty packet");
    check("R10 no underrun", underrun, 0);
    pulse_in();
    get_zlp("R10 freed");
    check("R10 freed underrun", underrun, 1);
    clear_underrun();
  endtask

  task automatic t_backpressure();
    load(3, 100);
    tx_ready = 0;
    pulse_in();
    for (int k = 0; k < 3; k++) begin
      check("R11 held data", tx_data, 100);
      check("R11 held sop", tx_sop, 1);
      @(negedge clk);
    end
    tx_ready = 1;
    @(negedge clk);
    check("R11 advance", tx_data, 101);
    @(negedge clk);
    check("R11 last", tx_eop, 1);
    @(negedge clk);
    check("R11 done", tx_valid, 0);
  endtask

  task automatic t_overflow();
    load(DEPTH + 3, 0);
    pulse_in();
    get_pkt(DEPTH, 0, "R12 saturate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_underrun();
    t_order();
    t_wait_sof();
    t_busy_in();
    t_zero_len();
    t_backpressure();
    t_overflow();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule